// File: doc/BRIEF.md
# External Interrupt Input Detector

This block takes six external interrupt request pins and one non-maskable interrupt (NMI) pin and turns them into pending requests. A 16-bit control register sets how each request pin is sensed: a falling edge, a rising edge or a low level. Edge-sensed requests are held until the interrupt logic sends a per-source clear strobe. Level-sensed requests follow the pin. Every pin passes through a two-flop synchronizer before it is examined.

The four lowest request pins can also be read as one 4-bit priority code instead of four separate requests. The block then gives out the code and a valid flag. Two global gates are built in. One masks every ordinary request while the NMI pin is low. The other makes the NMI request depend on a block bit that comes from outside. Arbitration between sources and vector generation are done elsewhere.

Top module: `irq_sense_unit`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x4000. With all pins held high, `irq_req_o`, `lvl_valid_o`, `lvl_code_o` and `nmi_req_o` are all zero.
- R2: A write (`cfg_we` high) stores all 16 bits of `cfg_wdata`. The new value is read back on `cfg_rdata` from the next clock edge. Bit 12 is stored but has no function.
- R3: The sense field for pin n is bits 2n+1:2n, so pin 5 uses bits 11:10 and pin 0 uses bits 1:0. Code 00 selects falling edge. A high-to-low change on the pin sets `irq_req_o[n]` three clock edges after the pin changes, and the request stays set after the pin returns high.
- R4: Code 01 selects rising edge. A low-to-high change sets the request three edges later, and a high-to-low change does not set it.
- R5: Codes 10 and 11 select low level. `irq_req_o[n]` is high exactly while the synchronized pin is low, two edges behind the pin, and it is never latched.
- R6: A one-cycle pulse on `irq_clr_i[n]` clears a latched edge request at that edge. A write that changes pin n's sense field also clears pin n's latched request at the write edge.
- R7: When bit 14 is 1, pins 3..0 form a code, with pin 3 as the MSB. A code other than 1111 gives `lvl_valid_o`=1 and `lvl_code_o` equal to the code. Code 1111 gives `lvl_valid_o`=0. `irq_req_o[3:0]` stays 0, and pins 4 and 5 keep their own sensing.
- R8: When bit 15 is 1 and the synchronized NMI pin is low, `irq_req_o` and `lvl_valid_o` are forced to 0. When bit 15 is 0, the NMI pin level does not affect them.
- R9: A falling edge on the NMI pin latches an NMI request, three edges after the pin changes. A pulse on `nmi_clr_i` clears it.
- R10: When bit 13 is 0 and `blk_i` is 1, `nmi_req_o` is 0, but the latched NMI request is kept. When bit 13 is 1, the latched request is shown whatever `blk_i` is.
- R11: When bit 14 is 0, `lvl_valid_o` and `lvl_code_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| irq_pin_i | input | 6 | Raw request pins (asynchronous) |
| nmi_pin_i | input | 1 | Raw NMI pin (asynchronous) |
| blk_i | input | 1 | Block bit from the processor status |
| irq_clr_i | input | 6 | Per-source clear of latched edge requests |
| nmi_clr_i | input | 1 | Clear of the latched NMI request |
| irq_req_o | output | 6 | Per-source request outputs |
| lvl_valid_o | output | 1 | Encoded priority code present |
| lvl_code_o | output | 4 | Encoded priority code |
| nmi_req_o | output | 1 | Gated NMI request |

## Verification
Faults in the synchronizer or in the previous-sample flops change the latency. An edge request then shows up one edge early or late, or it fires on the wrong polarity. Sampling exactly at the second and third edges exposes this at once. A latch that is not cleared shows as a request that survives a clear strobe or a sense change, and this is visible one cycle after the clear. A wrong masking or gating term shows on the very cycle the synchronized NMI pin or the block bit changes. The mask-all term shows on a request output, and the gating term shows on the NMI output.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    parameter int unsigned IRQS_PINS   = 6;
    parameter int unsigned IRQS_ENC    = 4;
    parameter int unsigned IRQS_CTRL_W = 16;
    parameter int unsigned IRQS_SYNC   = 2;
    parameter logic [15:0] IRQS_CTRL_RST = 16'h4000;

    typedef enum logic [1:0] {
        SENSE_FALL  = 2'b00,
        SENSE_RISE  = 2'b01,
        SENSE_LEVEL = 2'b10
    } sense_t;

    // Field order matches the register bit order (MSB first).
    typedef struct packed {
        logic        mask_all;    // 15: mask requests while NMI pin low
        logic        enc_mode;    // 14: lower pins form a priority code
        logic        nmi_always;  // 13: NMI ignores the block bit
        logic        spare;       // 12: stored only
        logic [11:0] sense;       // 2 bits per pin
    } ctrl_t;

    function automatic sense_t decode_sense(input logic [1:0] f);
        case (f)
            2'b00:   return SENSE_FALL;
            2'b01:   return SENSE_RISE;
            default: return SENSE_LEVEL;
        endcase
    endfunction

    function automatic logic code_idle(input logic [IRQS_ENC-1:0] c);
        return &c;
    endfunction
endpackage

// File: rtl/irqs_sync.sv
module irqs_sync #(
    parameter int unsigned W      = 7,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqs_ctrl_reg.sv
module irqs_ctrl_reg
    import irqs_pkg::*;
#(
    parameter int unsigned NPINS = IRQS_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [15:0]      wdata,
    output ctrl_t            ctrl_o,
    output logic [NPINS-1:0] flush_o
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_w;

    assign ctrl_w = ctrl_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst)     ctrl_q <= ctrl_t'(IRQS_CTRL_RST);
        else if (we) ctrl_q <= ctrl_w;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_flush
        assign flush_o[p] = we && (ctrl_w.sense[2*p +: 2] != ctrl_q.sense[2*p +: 2]);
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irqs_pin_detect.sv
module irqs_pin_detect
    import irqs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_s,
    input  sense_t sense,
    input  logic   clr,
    input  logic   flush,
    input  logic   hold_off,
    output logic   req_o
);
    logic prev_q;
    logic pend_q;
    logic hit;

    always_comb begin
        case (sense)
            SENSE_FALL: hit = prev_q & ~pin_s;
            SENSE_RISE: hit = ~prev_q & pin_s;
            default:    hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (flush || hold_off || sense == SENSE_LEVEL)
                pend_q <= 1'b0;
            else
                pend_q <= (pend_q & ~clr) | hit;
        end
    end

    assign req_o = (sense == SENSE_LEVEL) ? ~pin_s : pend_q;
endmodule

// File: rtl/irqs_nmi_detect.sv
module irqs_nmi_detect (
    input  logic clk,
    input  logic rst,
    input  logic nmi_s,
    input  logic clr,
    input  logic blk,
    input  logic pass_always,
    output logic req_o
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_s;
            pend_q <= (pend_q & ~clr) | (prev_q & ~nmi_s);
        end
    end

    assign req_o = pend_q & (pass_always | ~blk);
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
    import irqs_pkg::*;
#(
    parameter int unsigned NPINS  = IRQS_PINS,
    parameter int unsigned NENC   = IRQS_ENC,
    parameter int unsigned STAGES = IRQS_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    input  logic [NPINS-1:0] irq_pin_i,
    input  logic             nmi_pin_i,
    input  logic             blk_i,
    input  logic [NPINS-1:0] irq_clr_i,
    input  logic             nmi_clr_i,
    output logic [NPINS-1:0] irq_req_o,
    output logic             lvl_valid_o,
    output logic [NENC-1:0]  lvl_code_o,
    output logic             nmi_req_o
);
    localparam int unsigned SW = NPINS + 1;

    ctrl_t            ctrl;
    logic [NPINS-1:0] flush;
    logic [SW-1:0]    sync_q;
    logic [NPINS-1:0] pin_s;
    logic             nmi_s;
    logic [NPINS-1:0] raw_req;
    logic             mask_now;
    logic [NENC-1:0]  code;

    irqs_ctrl_reg #(.NPINS(NPINS)) u_reg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .ctrl_o(ctrl), .flush_o(flush)
    );

    irqs_sync #(.W(SW), .STAGES(STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk(clk), .rst(rst), .d({nmi_pin_i, irq_pin_i}), .q(sync_q)
    );

    assign pin_s = sync_q[NPINS-1:0];
    assign nmi_s = sync_q[SW-1];
    assign mask_now = ctrl.mask_all & ~nmi_s;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam bit IN_ENC = (p < NENC);
        logic enc_here;
        assign enc_here = IN_ENC && ctrl.enc_mode;

        irqs_pin_detect u_det (
            .clk(clk), .rst(rst), .pin_s(pin_s[p]),
            .sense(decode_sense(ctrl.sense[2*p +: 2])),
            .clr(irq_clr_i[p]), .flush(flush[p]), .hold_off(enc_here),
            .req_o(raw_req[p])
        );

        assign irq_req_o[p] = raw_req[p] & ~enc_here & ~mask_now;
    end

    assign code        = pin_s[NENC-1:0];
    assign lvl_valid_o = ctrl.enc_mode & ~code_idle(code) & ~mask_now;
    assign lvl_code_o  = lvl_valid_o ? code : '0;

    irqs_nmi_detect u_nmi (
        .clk(clk), .rst(rst), .nmi_s(nmi_s), .clr(nmi_clr_i),
        .blk(blk_i), .pass_always(ctrl.nmi_always), .req_o(nmi_req_o)
    );

    assign cfg_rdata = ctrl;
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [15:0] cfg_wdata,
    input logic [15:0] cfg_rdata,
    input logic        nmi_s,
    input logic        blk_i,
    input logic [5:0]  irq_req_o,
    input logic        lvl_valid_o,
    input logic [3:0]  lvl_code_o,
    input logic        nmi_req_o
);
    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_rdata == 16'h4000); // R1
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R2
    AST_ENC_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[14] |-> irq_req_o[3:0] == 4'b0000); // R7
    AST_CODE_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
        lvl_valid_o |-> lvl_code_o != 4'hF); // R7
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[15] && !nmi_s) |-> (irq_req_o == 6'b0 && !lvl_valid_o)); // R8
    AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[13] && blk_i) |-> !nmi_req_o); // R10
    AST_INDEP_NO_CODE: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[14] |-> (!lvl_valid_o && lvl_code_o == 4'h0)); // R11
endmodule

bind irq_sense_unit irqs_checker u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .nmi_s(nmi_s), .blk_i(blk_i),
    .irq_req_o(irq_req_o), .lvl_valid_o(lvl_valid_o),
    .lvl_code_o(lvl_code_o), .nmi_req_o(nmi_req_o)
);

// File: tb/test_irq_sense_unit.sv
module test_irq_sense_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [5:0]  irq_pin_i = 6'h3F;
    logic        nmi_pin_i = 1'b1;
    logic        blk_i = 1'b0;
    logic [5:0]  irq_clr_i = '0;
    logic        nmi_clr_i = 1'b0;
    logic [5:0]  irq_req_o;
    logic        lvl_valid_o;
    logic [3:0]  lvl_code_o;
    logic        nmi_req_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    irq_sense_unit i_irq_sense_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_pin_i(irq_pin_i), .nmi_pin_i(nmi_pin_i),
        .blk_i(blk_i), .irq_clr_i(irq_clr_i), .nmi_clr_i(nmi_clr_i),
        .irq_req_o(irq_req_o), .lvl_valid_o(lvl_valid_o),
        .lvl_code_o(lvl_code_o), .nmi_req_o(nmi_req_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr(input logic [5:0] m);
        irq_clr_i = m;
        tick(1);
        irq_clr_i = '0;
    endtask

    task automatic pulse_nmi_clr();
        nmi_clr_i = 1'b1;
        tick(1);
        nmi_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", cfg_rdata, 16'h4000);
        chk("R1 irq_req", 16'(irq_req_o), 16'h0);
        chk("R1 lvl_valid", 16'(lvl_valid_o), 16'h0);
        chk("R1 lvl_code", 16'(lvl_code_o), 16'h0);
        chk("R1 nmi_req", 16'(nmi_req_o), 16'h0);
    endtask

    task automatic t_regrw();
        wr(16'hA5C3);
        chk("R2 readback A5C3", cfg_rdata, 16'hA5C3);
        wr(16'h1000);
        chk("R2 readback spare bit", cfg_rdata, 16'h1000);
        wr(16'h0000);
        chk("R2 readback zero", cfg_rdata, 16'h0000);
    endtask

    task automatic t_fall();
        irq_pin_i[0] = 1'b0;
        tick(2);
        chk("R3 fall not yet", 16'(irq_req_o[0]), 16'h0);
        tick(1);
        chk("R3 fall latched", 16'(irq_req_o[0]), 16'h1);
        irq_pin_i[0] = 1'b1;
        tick(4);
        chk("R3 fall held", 16'(irq_req_o[0]), 16'h1);
        pulse_clr(6'b000001);
        chk("R6 clear strobe", 16'(irq_req_o[0]), 16'h0);
    endtask

    task automatic t_rise();
        wr(16'h0100);
        irq_pin_i[4] = 1'b0;
        tick(4);
        chk("R4 no req on fall", 16'(irq_req_o[4]), 16'h0);
        irq_pin_i[4] = 1'b1;
        tick(2);
        chk("R4 rise not yet", 16'(irq_req_o[4]), 16'h0);
        tick(1);
        chk("R4 rise latched", 16'(irq_req_o[4]), 16'h1);
        pulse_clr(6'b010000);
        chk("R6 rise cleared", 16'(irq_req_o[4]), 16'h0);
    endtask

    task automatic t_level();
        wr(16'h080C);
        irq_pin_i[5] = 1'b0;
        tick(1);
        chk("R5 level not yet", 16'(irq_req_o[5]), 16'h0);
        tick(1);
        chk("R5 level code10 active", 16'(irq_req_o[5]), 16'h1);
        irq_pin_i[5] = 1'b1;
        tick(2);
        chk("R5 level not latched", 16'(irq_req_o[5]), 16'h0);
        irq_pin_i[1] = 1'b0;
        tick(2);
        chk("R5 level code11 active", 16'(irq_req_o[1]), 16'h1);
        irq_pin_i[1] = 1'b1;
        tick(2);
        chk("R5 level code11 released", 16'(irq_req_o[1]), 16'h0);
    endtask

    task automatic t_modechg();
        wr(16'h0000);
        irq_pin_i[2] = 1'b0;
        tick(3);
        chk("R3 pin2 latched", 16'(irq_req_o[2]), 16'h1);
        irq_pin_i[2] = 1'b1;
        tick(2);
        wr(16'h0010);
        chk("R6 sense change clears", 16'(irq_req_o[2]), 16'h0);
        tick(3);
        chk("R6 stays clear", 16'(irq_req_o), 16'h0);
    endtask

    task automatic t_enc();
        wr(16'h4000);
        irq_pin_i[3:0] = 4'b0101;
        tick(2);
        chk("R7 code valid", 16'(lvl_valid_o), 16'h1);
        chk("R7 code value", 16'(lvl_code_o), 16'h5);
        chk("R7 low requests zero", 16'(irq_req_o[3:0]), 16'h0);
        irq_pin_i[3:0] = 4'b0000;
        tick(2);
        chk("R7 code zero valid", {11'h0, lvl_valid_o, lvl_code_o}, 16'h0010);
        irq_pin_i[3:0] = 4'b1111;
        tick(2);
        chk("R7 idle code", 16'(lvl_valid_o), 16'h0);
        irq_pin_i[5] = 1'b0;
        tick(3);
        chk("R7 pin5 still sensed", 16'(irq_req_o), 16'h0020);
        irq_pin_i[5] = 1'b1;
        pulse_clr(6'b100000);
        tick(2);
        wr(16'h0000);
        chk("R11 no code in independent", {11'h0, lvl_valid_o, lvl_code_o}, 16'h0);
        chk("R7 no stale low requests", 16'(irq_req_o), 16'h0);
    endtask

    task automatic t_mask();
        wr(16'h8800);
        irq_pin_i[5] = 1'b0;
        tick(2);
        chk("R8 req before mask", 16'(irq_req_o[5]), 16'h1);
        nmi_pin_i = 1'b0;
        tick(2);
        chk("R8 masked while NMI low", 16'(irq_req_o), 16'h0);
        tick(1);
        chk("R9 nmi latched", 16'(nmi_req_o), 16'h1);
        pulse_nmi_clr();
        chk("R9 nmi cleared", 16'(nmi_req_o), 16'h0);
        nmi_pin_i = 1'b1;
        tick(2);
        chk("R8 unmasked", 16'(irq_req_o[5]), 16'h1);
        wr(16'h0800);
        nmi_pin_i = 1'b0;
        tick(2);
        chk("R8 no mask when bit15 clear", 16'(irq_req_o[5]), 16'h1);
        tick(1);
        pulse_nmi_clr();
        nmi_pin_i = 1'b1;
        irq_pin_i[5] = 1'b1;
        tick(3);
    endtask

    task automatic t_nmi();
        wr(16'h0000);
        nmi_pin_i = 1'b0;
        tick(2);
        chk("R9 nmi not yet", 16'(nmi_req_o), 16'h0);
        tick(1);
        chk("R9 nmi on falling edge", 16'(nmi_req_o), 16'h1);
        nmi_pin_i = 1'b1;
        tick(3);
        chk("R9 nmi held", 16'(nmi_req_o), 16'h1);
        blk_i = 1'b1;
        tick(1);
        chk("R10 blocked by block bit", 16'(nmi_req_o), 16'h0);
        wr(16'h2000);
        chk("R10 bit13 passes", 16'(nmi_req_o), 16'h1);
        pulse_nmi_clr();
        chk("R9 cleared", 16'(nmi_req_o), 16'h0);
        blk_i = 1'b0;
        tick(1);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            report();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_regrw();
        t_fall();
        t_rise();
        t_level();
        t_modechg();
        t_enc();
        t_mask();
        t_nmi();
        report();
        $finish;
    end
endmodule